// File: doc/BRIEF.md
# Serial Program/Verify Command Interface

This block is the device-side port that an external programmer uses to load and verify the on-chip non-volatile memories. The programmer drives a slow serial clock pin and a data pin. Programming mode is entered by raising a high-voltage detect input while both pins are held low. While the mode is active the block holds the rest of the chip in reset. It takes 6-bit commands, least significant bit first, and decodes them. Load commands are followed by a 16-clock data frame that carries a 14-bit word. Read commands cause the block to drive a 16-clock frame back out on the data pin.

The pins are asynchronous to the block, so they are sampled by a fast system clock through a synchroniser chain. Clock edges are then detected on the sampled level. Decoded commands leave the block as single-cycle strobes. These go to the address counter (jump to configuration space, increment), to the memory write port (program or data space, with the word), to the read port, to the self-timed programming sequencer and to the two bulk-erase engines. A busy input from the sequencer blocks new programming and erase starts.

Top module: `serial_prog_port`

## Requirements
- R1: `prog_mode_o` goes high only if `pclk_i` and `pdat_i` are both low when the synchronised `hv_det_i` rises. If either pin is high at that moment, the mode stays off until `hv_det_i` falls and rises again. `prog_mode_o` is the reset hold for the rest of the chip.
- R2: When `hv_det_i` falls, the mode ends, `pdat_oe_o` drops and no strobe is issued. A partly received command or frame is discarded, so the next command after re-entry decodes correctly.
- R3: A command is six `pclk_i` cycles. Each bit is taken at a falling edge, bit 0 first. The codes, as bits 5..0, are:
  - load config 000000
  - load program 000010
  - read program 000100
  - increment address 000110
  - begin programming 001000
  - load data memory 000011
  - read data memory 000101
  - bulk erase program 001001
  - bulk erase data 001011
  
  Increment address pulses `addr_inc_o`.
- R4: A load frame is 16 cycles. The falling edges of cycles 2 to 15 carry data bits 0 to 13. At the falling edge of cycle 16, `wr_prog_o` pulses (or `wr_data_o` for load data memory) with the word on `wr_word_o`. Load config also pulses `addr_cfg_o` when the command is decoded.
- R5: A read command pulses `rd_req_o`, with `rd_dmem_o` high for read data memory and low for read program. `rd_word_i` is sampled in that cycle. The `pdat_o` output is low after the rising edge of cycle 1. After the rising edge of cycle k+2 it is data bit k, for k from 0 to 13. After the rising edge of cycle 16 it is low again.
- R6: `pdat_oe_o` rises together with `rd_req_o`. It stays high through the read frame and falls after the falling edge of the frame's 16th cycle. At all other times it is low.
- R7: Begin programming pulses `start_prog_o`. The two bulk erase commands pulse `erase_prog_o` and `erase_data_o`. Each of these pulses is suppressed if `busy_i` is high when the command completes.
- R8: An unrecognised code produces no strobe and takes no data frame: the next six clocks form a new command.
- R9: Every strobe lasts one system cycle, and at most one strobe is high at a time. A strobe appears on the SYNC_STAGES+1-th rising system edge after the pin edge that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_det_i | input | 1 | High-voltage detect; its rise is the mode entry request |
| pclk_i | input | 1 | Serial clock pin |
| pdat_i | input | 1 | Serial data pin, input path |
| pdat_o | output | 1 | Serial data pin, output path |
| pdat_oe_o | output | 1 | Output enable for the data pin |
| busy_i | input | 1 | Self-timed programming or erase in progress |
| rd_word_i | input | DATA_W | Word from the selected memory for a read |
| prog_mode_o | output | 1 | Mode active; holds the remaining logic in reset |
| addr_cfg_o | output | 1 | Set the address counter to configuration space |
| addr_inc_o | output | 1 | Increment the address counter |
| wr_prog_o | output | 1 | Write `wr_word_o` to program/configuration memory |
| wr_data_o | output | 1 | Write `wr_word_o` to data memory |
| wr_word_o | output | DATA_W | Word received in a load frame |
| rd_req_o | output | 1 | Read request; `rd_word_i` is taken in this cycle |
| rd_dmem_o | output | 1 | Read targets data memory |
| start_prog_o | output | 1 | Start a self-timed programming cycle |
| erase_prog_o | output | 1 | Start a bulk erase of program memory |
| erase_data_o | output | 1 | Start a bulk erase of data memory |

## Verification
Each strobe and each new `pdat_o` bit is due three system cycles after the serial pin edge that causes it: two synchroniser stages plus the edge-detect register. The bench holds every serial half-period for eight system cycles and samples `pdat_o` at the end of the half-period, so the value has settled well before it is read. Strobes are counted at every falling system edge, and each command's deltas are compared against an expected strobe mask after the command and its frame. One directed test fixes the exact cycle: it checks that `addr_inc_o` is low two falling system edges after the pin edge, high on the third and low on the fourth.

// File: rtl/spp_pkg.sv
package spp_pkg;

   localparam int CMD_W = 6;

   localparam logic [CMD_W-1:0] C_LD_CFG   = 6'b000000;
   localparam logic [CMD_W-1:0] C_LD_PROG  = 6'b000010;
   localparam logic [CMD_W-1:0] C_RD_PROG  = 6'b000100;
   localparam logic [CMD_W-1:0] C_INC      = 6'b000110;
   localparam logic [CMD_W-1:0] C_BEGIN    = 6'b001000;
   localparam logic [CMD_W-1:0] C_LD_DATA  = 6'b000011;
   localparam logic [CMD_W-1:0] C_RD_DATA  = 6'b000101;
   localparam logic [CMD_W-1:0] C_ERA_PROG = 6'b001001;
   localparam logic [CMD_W-1:0] C_ERA_DATA = 6'b001011;

   typedef enum logic [1:0] {ST_OFF, ST_CMD, ST_LOAD, ST_READ} st_t;

   typedef struct packed {
      logic ld;
      logic rd;
      logic dmem;
      logic cfg;
      logic inc;
      logic start;
      logic era_p;
      logic era_d;
   } dec_t;

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/spp_decode.sv
module spp_decode
   import spp_pkg::*;
(
   input  logic [CMD_W-1:0] code_i,
   output dec_t             dec_o
);

   always_comb begin
      dec_o = '0;
      case (code_i)
         C_LD_CFG:   begin dec_o.ld = 1'b1; dec_o.cfg  = 1'b1; end
         C_LD_PROG:  dec_o.ld = 1'b1;
         C_LD_DATA:  begin dec_o.ld = 1'b1; dec_o.dmem = 1'b1; end
         C_RD_PROG:  dec_o.rd = 1'b1;
         C_RD_DATA:  begin dec_o.rd = 1'b1; dec_o.dmem = 1'b1; end
         C_INC:      dec_o.inc   = 1'b1;
         C_BEGIN:    dec_o.start = 1'b1;
         C_ERA_PROG: dec_o.era_p = 1'b1;
         C_ERA_DATA: dec_o.era_d = 1'b1;
         default:    dec_o = '0;
      endcase
   end

endmodule

// File: rtl/spp_frame.sv
module spp_frame
   import spp_pkg::*;
#(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_i,
   input  logic              hv_rise_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              sclk_rise_i,
   input  logic              sclk_fall_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              mode_o,
   output logic              pdat_o,
   output logic              pdat_oe_o,
   output logic              addr_cfg_o,
   output logic              addr_inc_o,
   output logic              wr_prog_o,
   output logic              wr_data_o,
   output logic [DATA_W-1:0] wr_word_o,
   output logic              rd_req_o,
   output logic              rd_dmem_o,
   output logic              start_o,
   output logic              era_prog_o,
   output logic              era_data_o
);

   localparam int FRAME_LEN = DATA_W + 2;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] D_LAST   = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] F_LAST   = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);

   st_t               st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] sr_q;
   logic              dmem_q;
   logic [CMD_W-1:0]  code;
   dec_t              dec;
   logic              in_data;

   // Code as it stands once the bit on the pin is shifted in (lsb first).
   assign code    = {sdat_i, cmd_q[CMD_W-1:1]};
   assign in_data = (cnt_q >= ONE) && (cnt_q <= D_LAST);

   spp_decode i_dec (
      .code_i (code),
      .dec_o  (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_OFF;
         cnt_q      <= '0;
         cmd_q      <= '0;
         sr_q       <= '0;
         dmem_q     <= 1'b0;
         pdat_o     <= 1'b0;
         addr_cfg_o <= 1'b0;
         addr_inc_o <= 1'b0;
         wr_prog_o  <= 1'b0;
         wr_data_o  <= 1'b0;
         wr_word_o  <= '0;
         rd_req_o   <= 1'b0;
         rd_dmem_o  <= 1'b0;
         start_o    <= 1'b0;
         era_prog_o <= 1'b0;
         era_data_o <= 1'b0;
      end else begin
         addr_cfg_o <= 1'b0;
         addr_inc_o <= 1'b0;
         wr_prog_o  <= 1'b0;
         wr_data_o  <= 1'b0;
         rd_req_o   <= 1'b0;
         start_o    <= 1'b0;
         era_prog_o <= 1'b0;
         era_data_o <= 1'b0;
         if (!hv_i) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            cmd_q  <= '0;
            pdat_o <= 1'b0;
         end else begin
            case (st_q)
               ST_OFF: begin
                  if (hv_rise_i && !sclk_i && !sdat_i) begin
                     st_q  <= ST_CMD;
                     cnt_q <= '0;
                  end
               end
               ST_CMD: begin
                  if (sclk_fall_i) begin
                     cmd_q <= code;
                     if (cnt_q == CMD_LAST) begin
                        cnt_q      <= '0;
                        dmem_q     <= dec.dmem;
                        addr_inc_o <= dec.inc;
                        start_o    <= dec.start & ~busy_i;
                        era_prog_o <= dec.era_p & ~busy_i;
                        era_data_o <= dec.era_d & ~busy_i;
                        if (dec.ld) begin
                           st_q       <= ST_LOAD;
                           addr_cfg_o <= dec.cfg;
                        end else if (dec.rd) begin
                           st_q      <= ST_READ;
                           rd_req_o  <= 1'b1;
                           rd_dmem_o <= dec.dmem;
                           pdat_o    <= 1'b0;
                        end
                     end else begin
                        cnt_q <= cnt_q + ONE;
                     end
                  end
               end
               ST_LOAD: begin
                  if (sclk_fall_i) begin
                     if (in_data) sr_q <= {sdat_i, sr_q[DATA_W-1:1]};
                     if (cnt_q == F_LAST) begin
                        st_q      <= ST_CMD;
                        cnt_q     <= '0;
                        wr_word_o <= sr_q;
                        wr_prog_o <= ~dmem_q;
                        wr_data_o <= dmem_q;
                     end else begin
                        cnt_q <= cnt_q + ONE;
                     end
                  end
               end
               ST_READ: begin
                  if (rd_req_o) begin
                     sr_q <= rd_word_i;
                  end else if (sclk_rise_i) begin
                     if (in_data) begin
                        pdat_o <= sr_q[0];
                        sr_q   <= sr_q >> 1;
                     end else begin
                        pdat_o <= 1'b0;
                     end
                  end
                  if (sclk_fall_i) begin
                     if (cnt_q == F_LAST) begin
                        st_q   <= ST_CMD;
                        cnt_q  <= '0;
                        pdat_o <= 1'b0;
                     end else begin
                        cnt_q <= cnt_q + ONE;
                     end
                  end
               end
               default: st_q <= ST_OFF;
            endcase
         end
      end
   end

   assign mode_o    = (st_q != ST_OFF);
   assign pdat_oe_o = (st_q == ST_READ);

   // R9: strobes are mutually exclusive
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_cfg_o, addr_inc_o, wr_prog_o, wr_data_o,
                rd_req_o, start_o, era_prog_o, era_data_o}));

   // R2: nothing leaves the block while the mode is off
   a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_o |-> (!pdat_oe_o && !addr_cfg_o && !addr_inc_o && !wr_prog_o &&
                   !wr_data_o && !rd_req_o && !start_o && !era_prog_o && !era_data_o));

   // R7: no programming or erase start on a busy cycle
   a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o || era_prog_o || era_data_o) |-> $past(!busy_i));

   // R4: a write never coincides with a driven data pin
   a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_prog_o || wr_data_o) |-> !pdat_oe_o);

   // R6: the pin turns around only together with a read request
   a_r6_oe_with_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdat_oe_o) |-> rd_req_o);

endmodule

// File: rtl/serial_prog_port.sv
module serial_prog_port #(
   parameter int DATA_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_det_i,
   input  logic              pclk_i,
   input  logic              pdat_i,
   output logic              pdat_o,
   output logic              pdat_oe_o,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              prog_mode_o,
   output logic              addr_cfg_o,
   output logic              addr_inc_o,
   output logic              wr_prog_o,
   output logic              wr_data_o,
   output logic [DATA_W-1:0] wr_word_o,
   output logic              rd_req_o,
   output logic              rd_dmem_o,
   output logic              start_prog_o,
   output logic              erase_prog_o,
   output logic              erase_data_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serial_prog_port: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("serial_prog_port: DATA_W must be at least 2");
   end

   logic [2:0] pins_s;
   logic       hv_s, sclk_s, sdat_s;
   logic       hv_prev_q, sclk_prev_q;

   spp_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hv_det_i, pclk_i, pdat_i}),
      .q_o   (pins_s)
   );

   assign {hv_s, sclk_s, sdat_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hv_prev_q   <= 1'b0;
         sclk_prev_q <= 1'b0;
      end else begin
         hv_prev_q   <= hv_s;
         sclk_prev_q <= sclk_s;
      end
   end

   spp_frame #(.DATA_W(DATA_W)) i_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .hv_i        (hv_s),
      .hv_rise_i   (hv_s & ~hv_prev_q),
      .sclk_i      (sclk_s),
      .sdat_i      (sdat_s),
      .sclk_rise_i (sclk_s & ~sclk_prev_q),
      .sclk_fall_i (~sclk_s & sclk_prev_q),
      .busy_i      (busy_i),
      .rd_word_i   (rd_word_i),
      .mode_o      (prog_mode_o),
      .pdat_o      (pdat_o),
      .pdat_oe_o   (pdat_oe_o),
      .addr_cfg_o  (addr_cfg_o),
      .addr_inc_o  (addr_inc_o),
      .wr_prog_o   (wr_prog_o),
      .wr_data_o   (wr_data_o),
      .wr_word_o   (wr_word_o),
      .rd_req_o    (rd_req_o),
      .rd_dmem_o   (rd_dmem_o),
      .start_o     (start_prog_o),
      .era_prog_o  (erase_prog_o),
      .era_data_o  (erase_data_o)
   );

   // R1: the mode can only switch on while the detect is high
   a_r1_mode_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode_o) |-> hv_prev_q);

endmodule

// File: tb/test_serial_prog_port.sv
module test_serial_prog_port;

   localparam int DW = 14;
   localparam int HP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hv = 1'b0, pclk = 1'b0, pdat = 1'b0, busy = 1'b0;
   logic [DW-1:0] rd_word = '0;
   logic          pdat_o, pdat_oe, mode;
   logic          a_cfg, a_inc, w_p, w_d, r_q, r_dm, st, e_p, e_d;
   logic [DW-1:0] w_word;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   serial_prog_port #(.DATA_W(DW), .SYNC_STAGES(2)) i_serial_prog_port (
      .clk(clk), .rst_n(rst_n), .hv_det_i(hv), .pclk_i(pclk), .pdat_i(pdat),
      .pdat_o(pdat_o), .pdat_oe_o(pdat_oe), .busy_i(busy), .rd_word_i(rd_word),
      .prog_mode_o(mode), .addr_cfg_o(a_cfg), .addr_inc_o(a_inc),
      .wr_prog_o(w_p), .wr_data_o(w_d), .wr_word_o(w_word),
      .rd_req_o(r_q), .rd_dmem_o(r_dm), .start_prog_o(st),
      .erase_prog_o(e_p), .erase_data_o(e_d)
   );

   // Strobe order {cfg, inc, wr_prog, wr_data, rd_req, start, erase_prog, erase_data}
   logic [7:0] strb;
   assign strb = {a_cfg, a_inc, w_p, w_d, r_q, st, e_p, e_d};
   int scnt [8];
   int snap [8];
   logic [DW-1:0] last_word = '0;
   logic          last_dmem = 1'b0;

   initial for (int k = 0; k < 8; k++) scnt[k] = 0;

   always @(negedge clk) begin
      for (int k = 0; k < 8; k++) if (strb[k]) scnt[k] = scnt[k] + 1;
      if (w_p || w_d) last_word = w_word;
      if (r_q) last_dmem = r_dm;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic take_snap();
      for (int k = 0; k < 8; k++) snap[k] = scnt[k];
   endtask

   function automatic logic [7:0] delta_mask();
      logic [7:0] m;
      for (int k = 0; k < 8; k++) m[k] = (scnt[k] - snap[k]) != 0;
      return m;
   endfunction

   function automatic int delta_sum();
      int s = 0;
      for (int k = 0; k < 8; k++) s += scnt[k] - snap[k];
      return s;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One serial clock cycle; returns pdat_o at the end of the high phase.
   task automatic ser_cycle(input logic b, output logic rb);
      pclk = 1'b1; pdat = b;
      wait_clk(HP);
      rb = pdat_o;
      pclk = 1'b0;
      wait_clk(HP);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      logic rb;
      for (int i = 0; i < 6; i++) ser_cycle(c[i], rb);
      pdat = 1'b0;
      wait_clk(20);
   endtask

   task automatic load_frame(input logic [DW-1:0] w);
      logic rb;
      ser_cycle(1'b0, rb);
      for (int i = 0; i < DW; i++) ser_cycle(w[i], rb);
      ser_cycle(1'b0, rb);
      pdat = 1'b0;
      wait_clk(20);
   endtask

   task automatic read_frame(output logic [DW-1:0] w, output logic sb, output logic pb,
                             output logic oe_all);
      logic rb;
      oe_all = 1'b1;
      ser_cycle(1'b0, sb);
      oe_all &= pdat_oe;
      for (int i = 0; i < DW; i++) begin
         ser_cycle(1'b0, rb);
         w[i] = rb;
         oe_all &= pdat_oe;
      end
      ser_cycle(1'b0, pb);
      oe_all &= (pdat_oe == 1'b0);
      wait_clk(20);
   endtask

   task automatic enter_mode();
      pclk = 1'b0; pdat = 1'b0; hv = 1'b1;
      wait_clk(10);
   endtask

   task automatic leave_mode();
      hv = 1'b0;
      wait_clk(10);
   endtask

   // {kind[1:0] (0 none, 1 load, 2 read), code[5:0], word[13:0], strobe mask[7:0]}
   localparam int NV = 10;
   localparam logic [29:0] VEC [NV] = '{
      {2'd1, 6'h00, 14'h3FF5, 8'hA0},
      {2'd1, 6'h02, 14'h2A5C, 8'h20},
      {2'd2, 6'h04, 14'h1234, 8'h08},
      {2'd0, 6'h06, 14'h0000, 8'h40},
      {2'd0, 6'h08, 14'h0000, 8'h04},
      {2'd1, 6'h03, 14'h00A5, 8'h10},
      {2'd2, 6'h05, 14'h3001, 8'h08},
      {2'd0, 6'h09, 14'h0000, 8'h02},
      {2'd0, 6'h0B, 14'h0000, 8'h01},
      {2'd0, 6'h3F, 14'h0000, 8'h00}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] rw;
      logic sb, pb, oe_ok, rb;

      wait_clk(5);
      // Reset state
      check("R1 reset mode", mode, 0);
      check("R6 reset oe", pdat_oe, 0);
      check("R9 reset strobes", strb, 0);
      rst_n = 1'b1;
      wait_clk(5);

      // R1: clock pin high while the detect rises -> no entry
      pclk = 1'b1; hv = 1'b1;
      wait_clk(10);
      pclk = 1'b0;
      wait_clk(10);
      check("R1 entry refused with clock high", mode, 0);
      leave_mode();
      pdat = 1'b1; hv = 1'b1;
      wait_clk(10);
      check("R1 entry refused with data high", mode, 0);
      leave_mode();
      enter_mode();
      check("R1 entry with pins low", mode, 1);

      // Table walk: R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         logic [1:0] kind;
         logic [5:0] code;
         logic [DW-1:0] word;
         logic [7:0] mask;
         {kind, code, word, mask} = VEC[v];
         rd_word = word;
         take_snap();
         send_cmd(code);
         if (kind == 2'd1) load_frame(word);
         if (kind == 2'd2) begin
            read_frame(rw, sb, pb, oe_ok);
            check("R5 read word", rw, word);
            check("R5 start and stop bits low", {sb, pb}, 2'b00);
            check("R6 oe held over frame, released after", oe_ok, 1);
            check("R5 read space select", last_dmem, code[0]);
         end
         if (kind == 2'd1) check("R4 written word", last_word, word);
         check("R3 R4 R7 R8 strobe set", delta_mask(), mask);
         check("R9 single pulse per strobe", delta_sum(), $countones(mask));
      end

      // R8: unknown code takes no frame; next six clocks are a command
      take_snap();
      send_cmd(6'h3F);
      send_cmd(6'h06);
      check("R8 command right after unknown code", delta_mask(), 8'h40);

      // R7: busy suppresses begin programming and erases
      busy = 1'b1;
      take_snap();
      send_cmd(6'h08);
      send_cmd(6'h09);
      send_cmd(6'h0B);
      check("R7 busy suppresses starts", delta_sum(), 0);
      busy = 1'b0;

      // R9: exact cycle of a strobe after the completing falling edge
      begin
         logic [5:0] c = 6'h06;
         for (int i = 0; i < 5; i++) ser_cycle(c[i], rb);
         pclk = 1'b1; pdat = c[5];
         wait_clk(HP);
         pclk = 1'b0;
         wait_clk(2);
         check("R9 strobe not yet at second edge", a_inc, 0);
         wait_clk(1);
         check("R9 strobe at third edge", a_inc, 1);
         wait_clk(1);
         check("R9 strobe lasts one cycle", a_inc, 0);
         pdat = 1'b0;
         wait_clk(20);
      end

      // R2: partial command discarded by detect drop
      ser_cycle(1'b1, rb);
      ser_cycle(1'b1, rb);
      ser_cycle(1'b1, rb);
      leave_mode();
      check("R2 mode off after drop", mode, 0);
      enter_mode();
      take_snap();
      send_cmd(6'h06);
      check("R2 clean decode after re-entry", delta_mask(), 8'h40);

      // R2 R6: drop during a read frame releases the pin
      rd_word = 14'h3FFF;
      send_cmd(6'h04);
      ser_cycle(1'b0, rb);
      ser_cycle(1'b0, rb);
      check("R6 oe high inside read frame", pdat_oe, 1);
      take_snap();
      leave_mode();
      check("R2 oe released on drop", pdat_oe, 0);
      check("R2 no strobes on drop", delta_sum(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule